// File: doc/BRIEF.md
# Hysteresis Threshold Pulse Counter

This block counts pulses in a stream of signed ADC samples. Each sample arrives in the low bits of a wider stream data word. A comparator with two trip levels turns the samples into a clean one-bit level. The upper level sets it and the lower level clears it, and samples between the two leave it as it was. This rejects noise and ringing near a single threshold. Each low-to-high change of that level is one pulse.

Pulses are summed by an unsigned counter. A run input gates the counter, and a synchronous clear input zeroes it. The count is a plain parallel output, ready for a register wrapper to sample. The input stream is forwarded unchanged to an output stream, so the block can sit in a sample path without disturbing it. Everything runs on one clock with an active-low synchronous reset.

Top module: `pulse_tally`

## Requirements
- R1: The sample is bits [SAMPLE_W-1:0] of `s_tdata`, read as two's complement. The bits above it have no effect on counting.
- R2: On a cycle with `s_tvalid` high and a sample strictly above HI_LVL (default -100), the internal level is high from the next clock edge.
- R3: On a cycle with `s_tvalid` high and a sample strictly below LO_LVL (default -150), the internal level is low from the next clock edge.
- R4: A valid sample in the closed band from LO_LVL to HI_LVL leaves the level unchanged, including samples exactly equal to either threshold.
- R5: Each low-to-high change of the level adds exactly one to `count`. The new value shows one clock edge after the edge that captured the sample. The level is low after reset.
- R6: `count` is unsigned and CNT_W bits wide. It wraps from all ones to zero.
- R7: `count` is zero after reset. While `run_en` is low, `count` holds its value, and rising changes in that window are dropped.
- R8: `clr` high zeroes `count` at the next edge. It overrides a simultaneous increment and leaves the comparator level untouched.
- R9: A cycle with `s_tvalid` low changes neither the level nor `count`, whatever `s_tdata` holds.
- R10: `m_tdata` and `m_tvalid` equal `s_tdata` and `s_tvalid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Counting enabled when high |
| clr | input | 1 | Synchronous zeroing of the count |
| s_tdata | input | BUS_W | Input stream word; the sample sits in the low SAMPLE_W bits |
| s_tvalid | input | 1 | Input stream valid |
| m_tdata | output | BUS_W | Forwarded stream word |
| m_tvalid | output | 1 | Forwarded stream valid |
| count | output | CNT_W | Pulse count |

## Verification
The bench keeps the default 14-bit sample, 32-bit word and the -100/-150 thresholds, so exact-threshold and one-past-threshold samples are driven at their true values. Upper word bits are loaded so that a sample read too wide would flip the comparison. The counter is built with CNT_W of 4, which brings the wrap from fifteen to zero within a few dozen pulses, where the default width would need billions.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;

   localparam int unsigned BUS_W_DEF    = 32;
   localparam int unsigned SAMPLE_W_DEF = 14;
   localparam int unsigned CNT_W_DEF    = 32;
   localparam int          HI_LVL_DEF   = -100;
   localparam int          LO_LVL_DEF   = -150;

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } lvl_e;

endpackage

// File: rtl/ptl_slicer.sv
module ptl_slicer
   import pulse_tally_pkg::*;
#(
   parameter int unsigned BUS_W    = BUS_W_DEF,
   parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
   parameter int          HI_LVL   = HI_LVL_DEF,
   parameter int          LO_LVL   = LO_LVL_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] word,
   input  logic             valid,
   output lvl_e             lvl_q
);

   localparam int SMAX = (1 << (SAMPLE_W - 1)) - 1;
   localparam int SMIN = -(1 << (SAMPLE_W - 1));
   localparam logic signed [SAMPLE_W-1:0] HI_S = SAMPLE_W'(HI_LVL);
   localparam logic signed [SAMPLE_W-1:0] LO_S = SAMPLE_W'(LO_LVL);

   if (HI_LVL <= LO_LVL) begin : g_bad_order
      $error("ptl_slicer: HI_LVL must exceed LO_LVL");
   end
   if (HI_LVL > SMAX || LO_LVL < SMIN) begin : g_bad_range
      $error("ptl_slicer: thresholds outside sample range");
   end

   logic signed [SAMPLE_W-1:0] samp;
   lvl_e                       lvl_d;

   if (SAMPLE_W == BUS_W) begin : g_full
      assign samp = word;
   end else begin : g_slice
      assign samp = word[SAMPLE_W-1:0];
   end

   always_comb begin
      lvl_d = lvl_q;
      if (valid) begin
         if (samp > HI_S)      lvl_d = LVL_HIGH;
         else if (samp < LO_S) lvl_d = LVL_LOW;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= LVL_LOW;
      else        lvl_q <= lvl_d;
   end

   p_set_high_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && samp > HI_S) |=> (lvl_q == LVL_HIGH));

   p_set_low_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && samp < LO_S) |=> (lvl_q == LVL_LOW));

   p_band_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && samp >= LO_S && samp <= HI_S) |=> $stable(lvl_q));

   p_idle_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(lvl_q));

endmodule

// File: rtl/ptl_rise.sv
module ptl_rise
   import pulse_tally_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  lvl_e lvl,
   output logic rise
);

   lvl_e seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= LVL_LOW;
      else        seen_q <= lvl;
   end

   assign rise = (lvl == LVL_HIGH) && (seen_q == LVL_LOW);

   p_one_shot_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/ptl_count.sv
module ptl_count #(
   parameter int unsigned CNT_W = pulse_tally_pkg::CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             clr,
   input  logic             bump,
   output logic [CNT_W-1:0] cnt
);

   if (CNT_W < 1) begin : g_bad_width
      $error("ptl_count: CNT_W must be at least 1");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (clr)           cnt <= '0;
      else if (run_en && bump) cnt <= cnt + ONE;
   end

   p_step_wrap_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && bump && !clr) |=> (cnt == $past(cnt) + ONE));

   p_stopped_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !clr) |=> $stable(cnt));

   p_clear_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/pulse_tally.sv
module pulse_tally
   import pulse_tally_pkg::*;
#(
   parameter int unsigned BUS_W    = BUS_W_DEF,
   parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
   parameter int unsigned CNT_W    = CNT_W_DEF,
   parameter int          HI_LVL   = HI_LVL_DEF,
   parameter int          LO_LVL   = LO_LVL_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             clr,
   input  logic [BUS_W-1:0] s_tdata,
   input  logic             s_tvalid,
   output logic [BUS_W-1:0] m_tdata,
   output logic             m_tvalid,
   output logic [CNT_W-1:0] count
);

   if (SAMPLE_W < 2 || SAMPLE_W > BUS_W) begin : g_bad_sample
      $error("pulse_tally: SAMPLE_W must lie in 2..BUS_W");
   end

   lvl_e lvl;
   logic rise;

   assign m_tdata  = s_tdata;
   assign m_tvalid = s_tvalid;

   ptl_slicer #(
      .BUS_W    (BUS_W),
      .SAMPLE_W (SAMPLE_W),
      .HI_LVL   (HI_LVL),
      .LO_LVL   (LO_LVL)
   ) u_slicer (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (s_tdata),
      .valid (s_tvalid),
      .lvl_q (lvl)
   );

   ptl_rise u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .rise  (rise)
   );

   ptl_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_en),
      .clr    (clr),
      .bump   (rise),
      .cnt    (count)
   );

   p_count_reset_r7 : assert property (@(posedge clk)
      !rst_n |=> (count == '0));

endmodule

// File: tb/pulse_tally_bench.sv
module pulse_tally_bench;

   localparam int unsigned BW = 32;
   localparam int unsigned CW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          run_en;
   logic          clr;
   logic [BW-1:0] s_tdata;
   logic          s_tvalid;
   logic [BW-1:0] m_tdata;
   logic          m_tvalid;
   logic [CW-1:0] count;

   int checks   = 0;
   int failures = 0;
   logic [CW-1:0] exp_cnt = '0;

   always #5 clk = ~clk;

   pulse_tally #(
      .BUS_W    (BW),
      .SAMPLE_W (14),
      .CNT_W    (CW),
      .HI_LVL   (-100),
      .LO_LVL   (-150)
   ) u_pulse_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .clr      (clr),
      .s_tdata  (s_tdata),
      .s_tvalid (s_tvalid),
      .m_tdata  (m_tdata),
      .m_tvalid (m_tvalid),
      .count    (count)
   );

   task automatic chk_cnt(input logic [CW-1:0] exp, input string tag);
      checks++;
      if (count !== exp) begin
         failures++;
         $display("FAIL %s count=%0d expected=%0d", tag, count, exp);
      end
   endtask

   task automatic chk_word(input logic [BW-1:0] act, input logic [BW-1:0] exp,
                           input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge: holds the inputs for one full cycle.
   task automatic drive(input logic [BW-1:0] w, input logic v);
      s_tdata  = w;
      s_tvalid = v;
      @(negedge clk);
   endtask

   task automatic idle();
      drive(32'h0, 1'b0);
   endtask

   // One full pulse: high sample then low sample, leaves the level low.
   task automatic pulse();
      drive(BW'(-60), 1'b1);
      drive(BW'(-200), 1'b1);
   endtask

   task automatic t_reset();
      chk_cnt('0, "R7 count after reset");
   endtask

   task automatic t_passthru();
      s_tdata = 32'hDEAD_BEEF; s_tvalid = 1'b0; #1;
      chk_word(m_tdata, 32'hDEAD_BEEF, "R10 tdata forward");
      chk_word({31'b0, m_tvalid}, 32'h0, "R10 tvalid low forward");
      @(negedge clk);
      s_tdata = 32'h1234_3000; s_tvalid = 1'b1; #1;
      chk_word(m_tdata, 32'h1234_3000, "R10 tdata forward valid");
      chk_word({31'b0, m_tvalid}, 32'h1, "R10 tvalid high forward");
      @(negedge clk);
      idle();
   endtask

   task automatic t_stopped();
      run_en = 1'b0;
      pulse(); pulse(); idle();
      chk_cnt(exp_cnt, "R7 pulses while stopped dropped");
      run_en = 1'b1;
   endtask

   task automatic t_basic();
      for (int i = 0; i < 3; i++) begin
         pulse();
         exp_cnt++;
         chk_cnt(exp_cnt, "R5 one count per pulse");
      end
   endtask

   task automatic t_thresholds();
      drive(BW'(-100), 1'b1); idle();
      chk_cnt(exp_cnt, "R4 sample equal to high threshold holds low");
      drive(BW'(-99), 1'b1); idle();
      exp_cnt++;
      chk_cnt(exp_cnt, "R2 one above high threshold sets level");
      drive(BW'(-150), 1'b1); drive(BW'(-99), 1'b1); idle();
      chk_cnt(exp_cnt, "R4 sample equal to low threshold holds high");
      drive(BW'(-151), 1'b1); drive(BW'(-99), 1'b1); idle();
      exp_cnt++;
      chk_cnt(exp_cnt, "R3 one below low threshold clears level");
      drive(BW'(-151), 1'b1);
   endtask

   task automatic t_band();
      drive(BW'(-120), 1'b1); drive(BW'(-130), 1'b1);
      drive(BW'(-101), 1'b1); idle();
      chk_cnt(exp_cnt, "R4 in-band samples hold level");
   endtask

   task automatic t_invalid();
      drive(BW'(-50), 1'b0); drive(BW'(-50), 1'b0); idle();
      chk_cnt(exp_cnt, "R9 invalid high samples ignored");
   endtask

   task automatic t_sign();
      drive(32'h0001_3F9C, 1'b1); idle();
      chk_cnt(exp_cnt, "R1 upper bits ignored, low field is -100");
      drive(32'hFFFF_1FFF, 1'b1); idle();
      exp_cnt++;
      chk_cnt(exp_cnt, "R1 low field +8191 counts despite upper bits");
   endtask

   task automatic t_clear();
      clr = 1'b1; idle(); clr = 1'b0;
      exp_cnt = '0;
      chk_cnt(exp_cnt, "R8 clear zeroes count");
      drive(BW'(-50), 1'b1); idle();
      chk_cnt(exp_cnt, "R8 clear keeps comparator high");
      drive(BW'(-200), 1'b1);
      drive(BW'(-50), 1'b1);
      clr = 1'b1; idle(); clr = 1'b0;
      chk_cnt(exp_cnt, "R8 clear wins over increment");
      drive(BW'(-200), 1'b1);
   endtask

   task automatic t_hold_stop();
      pulse(); pulse();
      exp_cnt += 2;
      chk_cnt(exp_cnt, "R5 two pulses counted");
      run_en = 1'b0;
      pulse(); pulse(); idle();
      chk_cnt(exp_cnt, "R7 count held while stopped");
      run_en = 1'b1;
   endtask

   task automatic t_wrap();
      while (exp_cnt != '1) begin
         pulse();
         exp_cnt++;
      end
      chk_cnt(exp_cnt, "R6 count at all ones");
      pulse();
      exp_cnt++;
      chk_cnt('0, "R6 wrap to zero");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; run_en = 1'b0; clr = 1'b0;
      s_tdata = '0; s_tvalid = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_passthru();
      t_stopped();
      t_basic();
      t_thresholds();
      t_band();
      t_invalid();
      t_sign();
      t_clear();
      t_hold_stop();
      t_wrap();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule